// File: doc/BRIEF.md
# Audio Clock-Regeneration N/CTS Selector

This block picks the N and CTS pair that an audio clock-regeneration packet must carry for a given video pixel clock. A lookup request presents the pixel clock in kHz. A fixed sixteen-entry threshold table is searched, and the first entry whose threshold is not below the request supplies N and CTS. If the clock is above the highest threshold, the block raises an unsupported flag and leaves the current pair alone.

A host can also write both values one byte at a time over a small write-only register bus. The bus holds six byte-wide shadow registers. With the atomic bit set, the live 20-bit outputs move only when the low N byte is written. All six bytes then land in the same cycle, so a downstream packet generator never sees a mixed pair. With the atomic bit clear, the live outputs follow the shadow registers after every write. A successful lookup loads the shadow registers and the live outputs together.

Top module: `acr_pair_select`

## Requirements
- R1: After reset the live N and CTS are zero, both control outputs are zero, and the unsupported flag and the commit strobe are low. The atomic bit is also clear.
- R2: A lookup picks the lowest-indexed table entry whose threshold in kHz is greater than or equal to the requested clock. A request equal to a threshold picks that entry, and a request one above it picks the next entry. The chosen pair is loaded into the shadow registers and the live outputs at the same edge, whatever the atomic setting.
- R3: For the thirteen integer-rate entries (25175, 25200, 27000, 27027, 40000, 54000, 54054, 65000, 74250, 83500, 106500, 108000 and 148500 kHz), N is 6144 and CTS equals the entry's threshold.
- R4: The three remaining entries use these pairs: 74176 kHz gives N=11648 and CTS=140625, 148352 kHz gives N=5824 and CTS=140625, and 297000 kHz gives N=5120 and CTS=247500.
- R5: A lookup above 297000 kHz sets the unsupported flag, gives no strobe and leaves the live pair unchanged. The next lookup that finds an entry clears the flag.
- R6: The bus byte map is as follows. Address 0 holds CTS[7:0], address 1 holds CTS[15:8] and address 3 holds N[7:0]. Address 4 holds N[15:8]. Address 2 holds CTS[19:16] in bits 3:0, the N-shift field in bits 5:4 and the manual-CTS bit in bit 7. Address 5 holds N[19:16] in bits 3:0 and the atomic bit in bit 7.
- R7: While the atomic bit is set, a write to any address other than 3 leaves every live output unchanged.
- R8: While the atomic bit is set, a write to address 3 moves all six shadow bytes, including the byte being written, to the live outputs at that same edge. The live outputs are N, CTS, manual-CTS and N-shift.
- R9: The commit strobe is high for exactly the one cycle after a successful lookup or an atomic commit. It stays low for unsupported lookups and for non-atomic writes.
- R10: While the atomic bit is clear, the live outputs take the updated shadow contents at the edge of each bus write. The atomic mode in force is the bit's value held before the write.
- R11: When a lookup and a bus write arrive in the same cycle, the lookup wins and the write is discarded. The discarded write leaves no trace in the shadow registers either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lookup_req | input | 1 | One-cycle request to search the table |
| pix_khz | input | KHZ_W | Requested pixel clock in kHz |
| bus_wr | input | 1 | Byte write strobe |
| bus_addr | input | 3 | Byte register address |
| bus_wdata | input | 8 | Byte write data |
| live_n | output | 20 | Live N value |
| live_cts | output | 20 | Live CTS value |
| live_cts_manual | output | 1 | Live manual-CTS enable |
| live_n_shift | output | 2 | Live N-shift field |
| commit_pulse | output | 1 | One-cycle strobe when the live pair is updated |
| audio_unsupported | output | 1 | Last lookup found no table entry |

## Verification
The assertions assume that every input is stable and known across each rising edge. They also assume that a bus write targets an address from 0 to 5, and that the commit-source check looks back only at the cycle just before. The bench changes every input on the falling edge. It only writes the six mapped addresses and holds all requests low through reset. It reads results on the falling edge after the capturing rising edge, where the live outputs and the strobe are settled.

// File: rtl/acr_pair_select.sv
module acr_pair_select #(
  parameter int KHZ_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lookup_req,
  input  logic [KHZ_W-1:0] pix_khz,
  input  logic             bus_wr,
  input  logic [2:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [19:0]      live_n,
  output logic [19:0]      live_cts,
  output logic             live_cts_manual,
  output logic [1:0]       live_n_shift,
  output logic             commit_pulse,
  output logic             audio_unsupported
);

  localparam int NUM_ENT = 16;
  localparam int IDX_W   = $clog2(NUM_ENT);
  localparam logic [31:0] TOP_KHZ = 32'd297000;

  function automatic logic [31:0] ent_khz(input int i);
    case (i)
      0: ent_khz = 32'd25175;   1: ent_khz = 32'd25200;
      2: ent_khz = 32'd27000;   3: ent_khz = 32'd27027;
      4: ent_khz = 32'd40000;   5: ent_khz = 32'd54000;
      6: ent_khz = 32'd54054;   7: ent_khz = 32'd65000;
      8: ent_khz = 32'd74176;   9: ent_khz = 32'd74250;
      10: ent_khz = 32'd83500;  11: ent_khz = 32'd106500;
      12: ent_khz = 32'd108000; 13: ent_khz = 32'd148352;
      14: ent_khz = 32'd148500; default: ent_khz = TOP_KHZ;
    endcase
  endfunction

  function automatic logic [19:0] ent_n(input int i);
    case (i)
      8: ent_n = 20'd11648;
      13: ent_n = 20'd5824;
      15: ent_n = 20'd5120;
      default: ent_n = 20'd6144;
    endcase
  endfunction

  function automatic logic [19:0] ent_cts(input int i);
    case (i)
      8, 13: ent_cts = 20'd140625;
      15: ent_cts = 20'd247500;
      default: ent_cts = ent_khz(i)[19:0];
    endcase
  endfunction

  logic             hit;
  logic [IDX_W-1:0] hit_idx;

  always_comb begin
    hit = 1'b0;
    hit_idx = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (32'(pix_khz) <= ent_khz(i)) begin
        hit = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  logic [19:0] sh_n, sh_cts, nx_n, nx_cts;
  logic        sh_man, sh_atom, nx_man, nx_atom;
  logic [1:0]  sh_shift, nx_shift;

  wire wr_go     = bus_wr && !lookup_req;
  wire commit_wr = wr_go && sh_atom && (bus_addr == 3'd3);

  always_comb begin
    nx_n = sh_n; nx_cts = sh_cts; nx_man = sh_man;
    nx_shift = sh_shift; nx_atom = sh_atom;
    if (wr_go) begin
      case (bus_addr)
        3'd0: nx_cts[7:0] = bus_wdata;
        3'd1: nx_cts[15:8] = bus_wdata;
        3'd2: begin
          nx_cts[19:16] = bus_wdata[3:0];
          nx_shift = bus_wdata[5:4];
          nx_man = bus_wdata[7];
        end
        3'd3: nx_n[7:0] = bus_wdata;
        3'd4: nx_n[15:8] = bus_wdata;
        3'd5: begin
          nx_n[19:16] = bus_wdata[3:0];
          nx_atom = bus_wdata[7];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_n <= '0; sh_cts <= '0; sh_man <= 1'b0; sh_shift <= '0; sh_atom <= 1'b0;
      live_n <= '0; live_cts <= '0; live_cts_manual <= 1'b0; live_n_shift <= '0;
      commit_pulse <= 1'b0;
      audio_unsupported <= 1'b0;
    end else if (lookup_req) begin
      if (hit) begin
        sh_n <= ent_n(int'(hit_idx));
        sh_cts <= ent_cts(int'(hit_idx));
        live_n <= ent_n(int'(hit_idx));
        live_cts <= ent_cts(int'(hit_idx));
        commit_pulse <= 1'b1;
        audio_unsupported <= 1'b0;
      end else begin
        commit_pulse <= 1'b0;
        audio_unsupported <= 1'b1;
      end
    end else begin
      sh_n <= nx_n; sh_cts <= nx_cts; sh_man <= nx_man;
      sh_shift <= nx_shift; sh_atom <= nx_atom;
      if ((wr_go && !sh_atom) || commit_wr) begin
        live_n <= nx_n;
        live_cts <= nx_cts;
        live_cts_manual <= nx_man;
        live_n_shift <= nx_shift;
      end
      commit_pulse <= commit_wr;
    end
  end

  a_r2_hit_commits: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_req && 32'(pix_khz) <= TOP_KHZ) |=> (commit_pulse && !audio_unsupported));

  a_r5_miss_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_req && 32'(pix_khz) > TOP_KHZ) |=>
      (audio_unsupported && !commit_pulse && $stable(live_n) && $stable(live_cts)));

  a_r7_atomic_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !lookup_req && sh_atom && bus_addr != 3'd3) |=>
      ($stable(live_n) && $stable(live_cts) && $stable(live_cts_manual) && $stable(live_n_shift)));

  a_r9_pulse_source: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |-> $past(lookup_req || (bus_wr && bus_addr == 3'd3)));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!lookup_req && !bus_wr) |=> (!commit_pulse && $stable(live_n) && $stable(live_cts)));

endmodule

// File: tb/test_acr_pair_select.sv
module test_acr_pair_select;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lookup_req = 1'b0;
  logic [19:0] pix_khz = '0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [19:0] live_n, live_cts;
  logic        live_cts_manual, commit_pulse, audio_unsupported;
  logic [1:0]  live_n_shift;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  acr_pair_select #(.KHZ_W(20)) i_acr_pair_select (
    .clk(clk), .rst_n(rst_n), .lookup_req(lookup_req), .pix_khz(pix_khz),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .live_n(live_n), .live_cts(live_cts), .live_cts_manual(live_cts_manual),
    .live_n_shift(live_n_shift), .commit_pulse(commit_pulse),
    .audio_unsupported(audio_unsupported)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic chk_live(input string req, input logic [19:0] en, input logic [19:0] ec);
    chk({req, " live_n"}, 32'(live_n), 32'(en));
    chk({req, " live_cts"}, 32'(live_cts), 32'(ec));
  endtask

  task automatic do_lookup(input logic [19:0] khz);
    @(negedge clk);
    lookup_req = 1'b1; pix_khz = khz;
    @(negedge clk);
    lookup_req = 1'b0;
  endtask

  task automatic do_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_live("R1", 20'd0, 20'd0);
    chk("R1 manual", 32'(live_cts_manual), 0);
    chk("R1 shift", 32'(live_n_shift), 0);
    chk("R1 pulse", 32'(commit_pulse), 0);
    chk("R1 unsupported", 32'(audio_unsupported), 0);
  endtask

  task automatic t_lookup(input string req, input logic [19:0] khz,
                          input logic [19:0] en, input logic [19:0] ec);
    do_lookup(khz);
    chk_live(req, en, ec);
    chk({req, " R9 pulse"}, 32'(commit_pulse), 1);
    chk({req, " unsupported"}, 32'(audio_unsupported), 0);
    @(negedge clk);
    chk("R9 pulse one cycle", 32'(commit_pulse), 0);
  endtask

  task automatic t_table();
    t_lookup("R3 exact first", 20'd25175, 20'd6144, 20'd25175);
    t_lookup("R2 one above", 20'd25176, 20'd6144, 20'd25200);
    t_lookup("R2 gap", 20'd30000, 20'd6144, 20'd40000);
    t_lookup("R2 lowest", 20'd1, 20'd6144, 20'd25175);
    t_lookup("R4 74176", 20'd74176, 20'd11648, 20'd140625);
    t_lookup("R3 74177", 20'd74177, 20'd6144, 20'd74250);
    t_lookup("R4 148352", 20'd148352, 20'd5824, 20'd140625);
    t_lookup("R4 150000", 20'd150000, 20'd5120, 20'd247500);
    t_lookup("R4 297000", 20'd297000, 20'd5120, 20'd247500);
  endtask

  task automatic t_unsupported();
    do_lookup(20'd297001);
    chk("R5 flag", 32'(audio_unsupported), 1);
    chk("R5 no pulse", 32'(commit_pulse), 0);
    chk_live("R5 hold", 20'd5120, 20'd247500);
    t_lookup("R5 recover", 20'd65000, 20'd6144, 20'd65000);
  endtask

  task automatic t_direct();
    do_write(3'd0, 8'h34);
    chk_live("R10 cts lo", 20'd6144, 20'h0FD34);
    chk("R10 no pulse", 32'(commit_pulse), 0);
    do_write(3'd2, 8'h9A);
    chk_live("R6 cts top", 20'd6144, 20'hAFD34);
    chk("R6 manual", 32'(live_cts_manual), 1);
    chk("R6 shift", 32'(live_n_shift), 1);
    do_write(3'd5, 8'h81);
    chk_live("R10 n top", 20'h11800, 20'hAFD34);
  endtask

  task automatic t_atomic();
    do_write(3'd2, 8'h05);
    chk_live("R7 after cts top", 20'h11800, 20'hAFD34);
    chk("R7 manual held", 32'(live_cts_manual), 1);
    do_write(3'd1, 8'h66);
    do_write(3'd0, 8'h77);
    do_write(3'd4, 8'h88);
    chk_live("R7 after n mid", 20'h11800, 20'hAFD34);
    chk("R7 no pulse", 32'(commit_pulse), 0);
    do_write(3'd3, 8'h99);
    chk_live("R8 commit", 20'h18899, 20'h56677);
    chk("R8 manual", 32'(live_cts_manual), 0);
    chk("R8 shift", 32'(live_n_shift), 0);
    chk("R9 commit pulse", 32'(commit_pulse), 1);
    @(negedge clk);
    chk("R9 commit one cycle", 32'(commit_pulse), 0);
  endtask

  task automatic t_collide();
    @(negedge clk);
    lookup_req = 1'b1; pix_khz = 20'd27000;
    bus_wr = 1'b1; bus_addr = 3'd1; bus_wdata = 8'h11;
    @(negedge clk);
    lookup_req = 1'b0; bus_wr = 1'b0;
    chk_live("R11 lookup wins", 20'd6144, 20'd27000);
    do_write(3'd3, 8'h00);
    chk_live("R11 write dropped", 20'h01800, 20'd27000);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_table();
    t_unsupported();
    t_direct();
    t_atomic();
    t_collide();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule